// File: doc/BRIEF.md
# Bit-Banged GPIO Port Controller

This block is a word-addressed register window that holds two general-purpose ports, A and D. Software controls an external NAND flash and a serial temperature sensor purely by writing and reading these ports. Three bits of the port A output register drive the flash control strobes, and the flash ready pin appears in the port A input register.

On port D, one output bit acts as the sensor clock and another carries the data sent to the sensor. Any write that flips the clock bit produces a single-cycle edge strobe for the sensor, carrying the new clock level and the data bit from the same write. The data the sensor returns appears in the port D input register.

Each port input register reads back the port's output bits masked by its output-enable register, ORed with that port's external pin. All other indices inside the window are plain storage. Read data is registered and is returned one cycle after the read strobe. Writes take effect on the clock edge that samples the write strobe.

Top module: `gpio_bitbang_ctrl`

## Requirements
- R1: After reset every register reads zero, `bus_rdata` is zero, and `flash_ale`, `flash_cle`, `flash_ce` and `sens_edge` are low.
- R2: A write to a storage index (any index below 23 other than 0x01 and 0x11) is returned unchanged by a later read of that index. The index is the byte address shifted right by two. The data is on `bus_rdata` one cycle after the cycle in which `bus_re` is high.
- R3: A read of index 0x01 returns (index 0x00 AND index 0x02), with bit 7 ORed with `flash_ready` as sampled in the read cycle.
- R4: `flash_ale` equals bit 6, `flash_cle` equals bit 5 and `flash_ce` equals bit 4 of the index 0x00 register. They change on the edge of the write.
- R5: A read of index 0x11 returns (index 0x10 AND index 0x12), with bit 4 ORed with `sens_dout` as sampled in the read cycle.
- R6: A write to index 0x10 whose bit 1 differs from the stored bit 1 raises `sens_edge` for exactly the one cycle after the write edge. In that cycle `sens_clk_lvl` equals the written bit 1 and `sens_din` equals the written bit 4.
- R7: A write to index 0x10 that leaves bit 1 unchanged, and any write to any other index, raises no `sens_edge`.
- R8: Writes to indices 0x01 and 0x11 do not change what those indices read.
- R9: Indices 23 to 31 read as zero, and writes to them have no effect.
- R10: `bus_rdata` holds its value in every cycle that follows a cycle without a read.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| flash_ready | input | 1 | Flash ready/busy pin |
| flash_ale | output | 1 | Flash address latch enable |
| flash_cle | output | 1 | Flash command latch enable |
| flash_ce | output | 1 | Flash chip enable |
| sens_dout | input | 1 | Serial data from the sensor |
| sens_edge | output | 1 | One-cycle clock-edge event to the sensor |
| sens_clk_lvl | output | 1 | Sensor clock level carried by the event |
| sens_din | output | 1 | Serial data to the sensor carried by the event |

## Verification
A corrupted output register shows up as wrong flash strobe levels on the cycle after the write. It also shows up on the next read of the matching input index, where the mask and pin merge expose every bit. If the stored clock bit went wrong, toggle detection would invert: a write meant to toggle would give no edge, or a write meant to leave the clock alone would give one. That error is visible in the cycle right after the write. A wrong read mux or a missing read hold shows up one cycle after the read strobe, or during idle cycles after a read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int IDX_PA_OUT = 'h00;
  localparam int IDX_PA_IN  = 'h01;
  localparam int IDX_PA_OE  = 'h02;
  localparam int IDX_PD_OUT = 'h10;
  localparam int IDX_PD_IN  = 'h11;
  localparam int IDX_PD_OE  = 'h12;

  localparam int PA_READY_BIT = 7;
  localparam int PA_ALE_BIT   = 6;
  localparam int PA_CLE_BIT   = 5;
  localparam int PA_CE_BIT    = 4;
  localparam int PD_CLK_BIT   = 1;
  localparam int PD_DATA_BIT  = 4;

  // input view: driven bits masked by enables, with one pin ORed in
  function automatic logic [31:0] merge_input(input logic [31:0] out_w,
                                              input logic [31:0] oe_w,
                                              input logic pin,
                                              input int pin_bit);
    logic [31:0] r;
    r = out_w & oe_w;
    r[pin_bit] = r[pin_bit] | pin;
    return r;
  endfunction
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int DW    = 32,
  parameter int NREG  = 23,
  parameter int IDX_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic [DW-1:0]             wdata,
  output logic [NREG-1:0][DW-1:0]   regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    wire hit = we && (widx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   regs[i] <= '0;
      else if (hit) regs[i] <= wdata;
    end
  end
endmodule

// File: rtl/gpio_clk_edge.sv
module gpio_clk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic cur_clk,
  input  logic new_clk,
  input  logic new_din,
  output logic edge_o,
  output logic lvl_o,
  output logic din_o
);
  wire toggle = wr_hit && (cur_clk != new_clk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_o <= 1'b0;
      lvl_o  <= 1'b0;
      din_o  <= 1'b0;
    end else begin
      edge_o <= toggle;
      if (toggle) begin
        lvl_o <= new_clk;
        din_o <= new_din;
      end
    end
  end

  // the stored clock bit (regfile) must agree with the level just issued
  AST_EDGE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> lvl_o == cur_clk);                                   // R6
  AST_EDGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> !edge_o);                                    // R7
  AST_EDGE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> din_o == $past(new_din));                            // R6
endmodule

// File: rtl/gpio_bitbang_ctrl.sv
module gpio_bitbang_ctrl #(
  parameter int ADDR_W = 7,
  parameter int DW     = 32,
  parameter int NREG   = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              flash_ready,
  output logic              flash_ale,
  output logic              flash_cle,
  output logic              flash_ce,
  input  logic              sens_dout,
  output logic              sens_edge,
  output logic              sens_clk_lvl,
  output logic              sens_din
);
  import gpio_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
    return IDX_W'(a >> 2);
  endfunction

  wire [IDX_W-1:0] idx = word_index(bus_addr);
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0] rd_word;

  gpio_regfile #(.DW(DW), .NREG(NREG), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .widx(idx),
    .wdata(bus_wdata), .regs(regs)
  );

  // flash control strobes come straight from port A output bits
  assign flash_ale = regs[IDX_PA_OUT][PA_ALE_BIT];
  assign flash_cle = regs[IDX_PA_OUT][PA_CLE_BIT];
  assign flash_ce  = regs[IDX_PA_OUT][PA_CE_BIT];

  wire pd_wr_hit = bus_we && (idx == IDX_W'(IDX_PD_OUT));

  gpio_clk_edge u_edge (
    .clk(clk), .rst_n(rst_n), .wr_hit(pd_wr_hit),
    .cur_clk(regs[IDX_PD_OUT][PD_CLK_BIT]),
    .new_clk(bus_wdata[PD_CLK_BIT]),
    .new_din(bus_wdata[PD_DATA_BIT]),
    .edge_o(sens_edge), .lvl_o(sens_clk_lvl), .din_o(sens_din)
  );

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == IDX_W'(i)) rd_word = regs[i];
    if (idx == IDX_W'(IDX_PA_IN))
      rd_word = merge_input(regs[IDX_PA_OUT], regs[IDX_PA_OE], flash_ready, PA_READY_BIT);
    else if (idx == IDX_W'(IDX_PD_IN))
      rd_word = merge_input(regs[IDX_PD_OUT], regs[IDX_PD_OE], sens_dout, PD_DATA_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_word;
  end

  AST_FLASH_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && idx == IDX_W'(IDX_PA_OUT)) |=> flash_ale == $past(bus_wdata[PA_ALE_BIT])); // R4
  AST_PA_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && idx == IDX_W'(IDX_PA_IN) && flash_ready) |=> bus_rdata[PA_READY_BIT]);    // R3
  AST_PD_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && idx == IDX_W'(IDX_PD_IN) && sens_dout) |=> bus_rdata[PD_DATA_BIT]);       // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));                                                     // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && idx >= IDX_W'(NREG)) |=> bus_rdata == '0);                                // R9
endmodule

// File: tb/tb_gpio_bitbang_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bitbang_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_re = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic flash_ready = 0, flash_ale, flash_cle, flash_ce;
  logic sens_dout = 0, sens_edge, sens_clk_lvl, sens_din;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic re_seen = 0;
  logic [31:0] last_exp = '0;

  always #2 clk = ~clk;

  gpio_bitbang_ctrl dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare one cycle after each read strobe
  always @(posedge clk) re_seen <= bus_re;
  always @(negedge clk) begin
    if (re_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(bus_rdata === e, t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_re = 1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    last_exp = e;
    @(negedge clk);
    bus_re = 0;
  endtask

  task automatic chk_edge(input bit e, input bit l, input bit d, input string tag);
    check(sens_edge === e, tag, {31'b0, sens_edge}, {31'b0, e});
    if (e) begin
      check(sens_clk_lvl === l, tag, {31'b0, sens_clk_lvl}, {31'b0, l});
      check(sens_din === d, tag, {31'b0, sens_din}, {31'b0, d});
      @(negedge clk);
      check(sens_edge === 1'b0, {tag, " one-cycle"}, {31'b0, sens_edge}, 32'h0);
    end
  endtask

  task automatic chk_flash(input logic [2:0] e, input string tag);
    check({flash_ale, flash_cle, flash_ce} === e, tag, {29'b0, flash_ale, flash_cle, flash_ce}, {29'b0, e});
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_flash(3'b000, "R1 strobes");
    check(sens_edge === 0, "R1 edge", {31'b0, sens_edge}, 0);
    check(bus_rdata === 0, "R1 rdata", bus_rdata, 0);
    rd(7'h00, 0, "R1 pa_out");
    rd(7'h48, 0, "R1 pd_oe");

    // R2 storage
    wr(7'h14, 32'hDEADBEEF);
    wr(7'h58, 32'h12345678);
    rd(7'h14, 32'hDEADBEEF, "R2 idx5");
    rd(7'h58, 32'h12345678, "R2 idx22");

    // R4 flash strobes
    wr(7'h00, 32'h70); chk_flash(3'b111, "R4 all");
    wr(7'h00, 32'h40); chk_flash(3'b100, "R4 ale");
    wr(7'h00, 32'h20); chk_flash(3'b010, "R4 cle");
    wr(7'h00, 32'h10); chk_flash(3'b001, "R4 ce");

    // R3 port A input
    wr(7'h08, 32'h0F);
    wr(7'h00, 32'h35);
    flash_ready = 0; rd(7'h04, 32'h05, "R3 masked");
    flash_ready = 1; rd(7'h04, 32'h85, "R3 ready");
    wr(7'h08, 32'h0);
    rd(7'h04, 32'h80, "R3 oe zero");
    flash_ready = 0;

    // R5 port D input, R7 no toggle
    wr(7'h48, 32'hFF);
    wr(7'h40, 32'h0C); chk_edge(0, 0, 0, "R7 bit1 same");
    sens_dout = 0; rd(7'h44, 32'h0C, "R5 masked");
    sens_dout = 1; rd(7'h44, 32'h1C, "R5 dout");
    wr(7'h48, 32'h04);
    rd(7'h44, 32'h14, "R5 oe");
    sens_dout = 0;

    // R6 toggles
    wr(7'h40, 32'h12); chk_edge(1, 1, 1, "R6 rise");
    wr(7'h40, 32'h02); chk_edge(0, 0, 0, "R7 hold high");
    wr(7'h40, 32'h00); chk_edge(1, 0, 0, "R6 fall");
    wr(7'h40, 32'h10); chk_edge(0, 0, 0, "R7 hold low");
    wr(7'h20, 32'h2);  chk_edge(0, 0, 0, "R7 other index");

    // R8 input indices ignore writes
    wr(7'h08, 32'hFF); wr(7'h00, 32'h03);
    wr(7'h04, 32'hFFFFFFFF);
    rd(7'h04, 32'h03, "R8 pa_in");
    wr(7'h44, 32'hFFFFFFFF);
    rd(7'h44, 32'h00, "R8 pd_in");

    // R9 unmapped
    wr(7'h5C, 32'hCAFE);
    rd(7'h5C, 0, "R9 idx23");
    wr(7'h7C, 32'hBEEF);
    rd(7'h7C, 0, "R9 idx31");
    rd(7'h14, 32'hDEADBEEF, "R9 no alias");

    // R10 hold
    repeat (4) @(negedge clk);
    check(bus_rdata === last_exp, "R10 hold", bus_rdata, last_exp);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule